// File: doc/BRIEF.md
# Phase-Frequency Comparator with Lock Detect

This block compares two single-bit pulse streams that are sampled on a fast system clock: a reference stream and a divided-down feedback stream taken from an oscillator loop. A detector built from two flags records which rising edge came first. It clears both flags when the opposite edge arrives. The result is a three-state command for an external charge pump: drive high, drive low, or release the line. A polarity input swaps the high and low levels, so one loop can serve an oscillator with either tuning slope.

A lock monitor measures each correction pulse in system-clock cycles. It declares lock only after a run of consecutive comparisons whose pulses stay narrower than a set window. It withdraws lock as soon as a pulse grows to the window width. A run input selects between operation and standby. In standby the pump line is released, the lock output reads as locked, and the detector is emptied, so the first comparison after wake-up starts from a known phase. The block always comes out of reset in standby.

Top module: `phase_lock_cmp`

## Requirements
- R1: With `pol_i` high, a reference edge ahead of the feedback edge gives `pump_en_o`=1 and `pump_hi_o`=1. A feedback edge ahead of the reference edge gives `pump_en_o`=1 and `pump_hi_o`=0.
- R2: With `pol_i` low, the levels are swapped: a leading reference gives `pump_hi_o`=0 and a leading feedback gives `pump_hi_o`=1, still with `pump_en_o`=1.
- R3: Rising edges on both inputs in the same cycle produce no drive (`pump_en_o` stays 0). That comparison counts as zero phase error.
- R4: An input edge sampled at clock edge k drives `pump_en_o` from cycle k onward. The drive ends at the clock edge that samples the opposite input's edge, so the pulse lasts as many cycles as the two edges are apart.
- R5: A second edge on the leading input before the lagging edge arrives does not end or restart the pulse. It ends only on the lagging input's edge, which allows up to a full period of phase error either way.
- R6: `lock_o` rises at the end of the `LOCK_RUNS`-th consecutive comparison whose pulse is shorter than `TW_CYCLES` cycles. A wide comparison in between restarts the count.
- R7: `lock_o` falls in the cycle right after a pulse has been active for `TW_CYCLES` cycles, even if that pulse has not ended.
- R8: One cycle after `run_i` goes low, the block is in standby: `pump_en_o`=0 and `lock_o`=1, whatever edges arrive.
- R9: After reset the block is in standby for at least one cycle, even with `run_i` high. It then leaves standby with `lock_o`=0 until R6 is met.
- R10: On leaving standby, a pulse that was in flight when standby began does not reappear. The lock state held before standby is restored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all sampling and state use its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | 1 | Reference pulse stream (rising edges compared) |
| fb_i | input | 1 | Divided feedback pulse stream |
| pol_i | input | 1 | Output polarity: 1 means a leading reference drives high |
| run_i | input | 1 | 1 selects operation, 0 selects standby (registered) |
| pump_en_o | output | 1 | Pump line driven when 1, released (high impedance) when 0 |
| pump_hi_o | output | 1 | Level to drive when `pump_en_o` is 1 |
| lock_o | output | 1 | Lock indication |

## Verification
A detector flag that fails to clear shows up at once as a pulse that runs past the lagging edge. Within `TW_CYCLES` cycles it also pulls `lock_o` low. A flag that clears too early shortens the pulse by the cycles it lost, and the first scored cycle catches that. A wrong streak count moves the `lock_o` rising edge by at least one whole comparison, so the checks watch the exact cycle of each lock change. A standby path that fails to empty the detector only shows after wake-up, as a drive with no new edge, so the cycles after resuming are scored one by one.

// File: rtl/plcmp_pkg.sv
package plcmp_pkg;

    localparam int CH_REF = 0;
    localparam int CH_FB  = 1;
    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        CMD_IDLE      = 2'b00,
        CMD_REF_AHEAD = 2'b01,
        CMD_FB_AHEAD  = 2'b10
    } pump_cmd_e;

    typedef struct packed {
        logic drive;
        logic level;
    } pump_out_t;

    function automatic pump_out_t map_cmd(input pump_cmd_e cmd, input logic pol);
        pump_out_t o;
        unique case (cmd)
            CMD_REF_AHEAD: o = '{drive: 1'b1, level: pol};
            CMD_FB_AHEAD:  o = '{drive: 1'b1, level: ~pol};
            default:       o = '{drive: 1'b0, level: 1'b0};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/plcmp_edge.sv
module plcmp_edge #(
    parameter int CH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CH-1:0] lvl,
    output logic [CH-1:0] rise
);

    for (genvar i = 0; i < CH; i++) begin : g_ch
        logic prev_q;
        always_ff @(posedge clk) begin
            if (rst) prev_q <= 1'b0;
            else     prev_q <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev_q;
    end

endmodule

// File: rtl/plcmp_pfd.sv
module plcmp_pfd
    import plcmp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      ref_rise,
    input  logic      fb_rise,
    output pump_cmd_e cmd,
    output logic      active,
    output logic      done
);

    logic up_q, dn_q;
    logic up_n, dn_n;

    always_comb begin
        up_n = up_q | ref_rise;
        dn_n = dn_q | fb_rise;
        done = run & up_n & dn_n;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else if (done) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= up_n;
            dn_q <= dn_n;
        end
    end

    always_comb begin
        active = up_q | dn_q;
        if (up_q)      cmd = CMD_REF_AHEAD;
        else if (dn_q) cmd = CMD_FB_AHEAD;
        else           cmd = CMD_IDLE;
    end

    // R3: coincident edges from an empty detector leave it empty
    assert_coincident_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (run && ref_rise && fb_rise && !up_q && !dn_q) |=> (!up_q && !dn_q));

    // R5: a leading pulse persists until the lagging edge
    assert_hold_lead_R5: assert property (@(posedge clk) disable iff (rst)
        (run && up_q && !fb_rise) |=> up_q);

    // R10: standby empties the detector
    assert_standby_clear_R10: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!up_q && !dn_q));

endmodule

// File: rtl/plcmp_lock.sv
module plcmp_lock #(
    parameter int TW_CYCLES = 16,
    parameter int LOCK_RUNS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic active,
    input  logic done,
    output logic locked
);

    localparam int CW = $clog2(TW_CYCLES + 1);
    localparam int RW = $clog2(LOCK_RUNS + 1);

    logic [CW-1:0] err_q;
    logic [RW-1:0] streak_q;
    logic          lock_q;
    logic [CW:0]   width_now;
    logic          too_wide;

    always_comb begin
        width_now = {1'b0, err_q} + {{CW{1'b0}}, active};
        too_wide  = width_now >= (CW+1)'(TW_CYCLES);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q    <= '0;
            streak_q <= '0;
            lock_q   <= 1'b0;
        end else if (!run) begin
            err_q    <= '0;
        end else begin
            if (done)
                err_q <= '0;
            else if (active && !too_wide)
                err_q <= err_q + 1'b1;

            if (too_wide) begin
                lock_q   <= 1'b0;
                streak_q <= '0;
            end else if (done) begin
                if (streak_q >= RW'(LOCK_RUNS - 1))
                    lock_q <= 1'b1;
                if (streak_q != RW'(LOCK_RUNS))
                    streak_q <= streak_q + 1'b1;
            end
        end
    end

    assign locked = lock_q;

    // R7: a pulse at the window width removes lock on the next edge
    assert_drop_wide_R7: assert property (@(posedge clk) disable iff (rst)
        (run && too_wide) |=> !lock_q);

    // R6: lock appears only after the full streak of narrow comparisons
    assert_rise_streak_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_q) |-> ($past(streak_q) == RW'(LOCK_RUNS - 1) && $past(done)));

    // R10: lock state is frozen through standby
    assert_hold_standby_R10: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(lock_q));

endmodule

// File: rtl/phase_lock_cmp.sv
module phase_lock_cmp
    import plcmp_pkg::*;
#(
    parameter int TW_CYCLES = 16,
    parameter int LOCK_RUNS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_i,
    input  logic fb_i,
    input  logic pol_i,
    input  logic run_i,
    output logic pump_en_o,
    output logic pump_hi_o,
    output logic lock_o
);

    logic              run_q;
    logic [NUM_CH-1:0] lvl;
    logic [NUM_CH-1:0] rise;
    pump_cmd_e         cmd;
    logic              active;
    logic              done;
    logic              locked;
    pump_out_t         pout;

    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= run_i;
    end

    always_comb begin
        lvl         = '0;
        lvl[CH_REF] = ref_i;
        lvl[CH_FB]  = fb_i;
    end

    plcmp_edge #(.CH(NUM_CH)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl),
        .rise (rise)
    );

    plcmp_pfd u_pfd (
        .clk      (clk),
        .rst      (rst),
        .run      (run_q),
        .ref_rise (rise[CH_REF]),
        .fb_rise  (rise[CH_FB]),
        .cmd      (cmd),
        .active   (active),
        .done     (done)
    );

    plcmp_lock #(
        .TW_CYCLES (TW_CYCLES),
        .LOCK_RUNS (LOCK_RUNS)
    ) u_lock (
        .clk    (clk),
        .rst    (rst),
        .run    (run_q),
        .active (active),
        .done   (done),
        .locked (locked)
    );

    always_comb begin
        pout      = map_cmd(cmd, pol_i);
        pump_en_o = run_q & pout.drive;
        pump_hi_o = pout.level;
        lock_o    = ~run_q | locked;
    end

    // R8: standby outputs follow run_i one cycle later
    assert_standby_out_R8: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (!pump_en_o && lock_o));

endmodule

// File: tb/tb_phase_lock_cmp.sv
module tb_phase_lock_cmp;

    localparam int TW = 5;
    localparam int LR = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_i = 1'b0, fb_i = 1'b0, pol_i = 1'b1, run_i = 1'b1;
    logic pump_en_o, pump_hi_o, lock_o;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        int    at;
        int    oe;
        int    hi;
        int    lk;
        string tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    phase_lock_cmp #(.TW_CYCLES(TW), .LOCK_RUNS(LR)) dut (
        .clk(clk), .rst(rst), .ref_i(ref_i), .fb_i(fb_i), .pol_i(pol_i),
        .run_i(run_i), .pump_en_o(pump_en_o), .pump_hi_o(pump_hi_o), .lock_o(lock_o)
    );

    task automatic push(input int at, input int oe, input int hi, input int lk, input string tag);
        exp_t e;
        e.at = at; e.oe = oe; e.hi = hi; e.lk = lk; e.tag = tag;
        q.push_back(e);
    endtask

    // scoreboard monitor: compare at the falling edge of the scheduled cycle
    always @(negedge clk) begin
        while (q.size() != 0 && q[0].at <= cyc) begin
            exp_t e;
            bit bad;
            e = q.pop_front();
            n_chk++;
            bad = (e.at != cyc) || (int'(pump_en_o) != e.oe) ||
                  (e.hi >= 0 && int'(pump_hi_o) != e.hi) ||
                  (e.lk >= 0 && int'(lock_o) != e.lk);
            if (bad) begin
                n_fail++;
                $display("FAIL %s cyc %0d: got en=%0d hi=%0d lock=%0d, expected en=%0d hi=%0d lock=%0d (sched %0d)",
                         e.tag, cyc, pump_en_o, pump_hi_o, lock_o, e.oe, e.hi, e.lk, e.at);
            end
        end
    end

    // gap > 0: reference leads by gap cycles; gap < 0: feedback leads
    task automatic pair(input int gap, input int lk_in, input int lk_end, input string tag);
        int g, rt, ft, n, hi;
        bit ref_leads;
        g = (gap < 0) ? -gap : gap;
        ref_leads = (gap >= 0);
        rt = ref_leads ? 0 : g;
        ft = ref_leads ? g : 0;
        hi = (ref_leads == pol_i) ? 1 : 0;
        @(posedge clk); #1;
        n = cyc;
        for (int k = 1; k <= g; k++)
            push(n + k, 1, hi, (k > TW) ? 0 : lk_in, tag);
        push(n + g + 1, 0, -1, lk_end, tag);
        for (int t = 0; t <= g; t++) begin
            if (t > 0) begin @(posedge clk); #1; end
            ref_i = (t == rt);
            fb_i  = (t == ft);
        end
        @(posedge clk); #1;
        ref_i = 1'b0; fb_i = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : driver
        int n;
        // R9: reset with run_i high still starts in standby
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        n = cyc;
        push(n, 0, -1, 1, "R9 standby after reset");
        push(n + 1, 0, -1, 0, "R9 unlocked after wake");
        repeat (3) @(posedge clk);

        // R6 lock after three narrow comparisons; R1 and R4 pulse shape
        pair(2, 0, 0, "R1/R4 ref lead");
        pair(-3, 0, 0, "R1/R4 fb lead");
        pair(1, 0, 1, "R6 third narrow");
        pair(0, 1, 1, "R3 coincident");
        pair(4, 1, 1, "R4 narrow 4");
        pair(5, 1, 0, "R7 width at window");
        pair(2, 0, 0, "R6 relock 1");
        pair(2, 0, 0, "R6 relock 2");
        pair(2, 0, 1, "R6 relock 3");
        pair(8, 1, 0, "R7 mid-pulse drop");
        // R6 streak broken by a wide comparison
        pair(2, 0, 0, "R6 streak a");
        pair(2, 0, 0, "R6 streak b");
        pair(6, 0, 0, "R6 wide breaks");
        pair(2, 0, 0, "R6 streak c");
        pair(-2, 0, 0, "R6 streak d");
        pair(2, 0, 1, "R6 streak e");
        // R2 polarity swap
        pol_i = 1'b0;
        pair(3, 1, 1, "R2 ref lead low pol");
        pair(-3, 1, 1, "R2 fb lead low pol");
        pol_i = 1'b1;

        // R5: second reference edge inside the pulse
        @(posedge clk); #1;
        n = cyc;
        for (int k = 1; k <= 4; k++) push(n + k, 1, 1, 1, "R5 double lead edge");
        push(n + 5, 0, -1, 1, "R5 ends on lag edge");
        ref_i = 1'b1;
        @(posedge clk); #1 ref_i = 1'b0;
        @(posedge clk); #1 ref_i = 1'b1;
        @(posedge clk); #1 ref_i = 1'b0;
        @(posedge clk); #1 fb_i = 1'b1;
        @(posedge clk); #1 fb_i = 1'b0;
        repeat (3) @(posedge clk);

        // R8 standby mid-pulse, R10 clean resume with lock kept
        @(posedge clk); #1;
        n = cyc;
        ref_i = 1'b1;
        push(n + 1, 1, 1, 1, "R8 pulse before standby");
        push(n + 2, 0, -1, 1, "R8 standby released");
        push(n + 3, 0, -1, 1, "R8 edge ignored");
        push(n + 4, 0, -1, 1, "R8 edge ignored");
        push(n + 5, 0, -1, 1, "R10 resume idle");
        push(n + 6, 0, -1, 1, "R10 resume idle");
        push(n + 7, 0, -1, 1, "R10 lock kept");
        @(posedge clk); #1 ref_i = 1'b0; run_i = 1'b0;
        @(posedge clk); #1 fb_i = 1'b1;
        @(posedge clk); #1 fb_i = 1'b0; ref_i = 1'b1;
        @(posedge clk); #1 ref_i = 1'b0; run_i = 1'b1;
        repeat (4) @(posedge clk);
        pair(2, 1, 1, "R10 normal after resume");

        wait (q.size() == 0);
        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule